// File: doc/BRIEF.md
# Far Transfer Privilege Checker

This block rules on whether a far jump or far call into a code segment may proceed, either straight to the segment or by way of a call gate. For each request it takes the transfer kind, the entry path, the current privilege level, the privilege level requested by the selector, the gate's privilege level and the target code segment's privilege level and conforming flag. It answers with a grant or a denial, the privilege level the processor runs at after the transfer, a flag saying whether a stack switch must follow, and a fault code when the transfer is refused.

Requests and responses use valid/ready handshakes. A single response register sits between them, so an accepted request produces its response on the following cycle. The response is held while the consumer stalls. Fetching the new stack, copying parameters and handling returns belong to other blocks.

Privilege levels are 2-bit numbers, where 0 is the most privileged. The effective level is the larger of the current level and the requested level.

Top module: `far_xfer_priv_chk`

## Requirements
- R1: After reset, rsp_valid_o is 0 and req_ready_o is 1.
- R2: req_ready_o equals (not rsp_valid_o) or rsp_ready_i. A request taken with req_valid_i and req_ready_o both high at a clock edge appears on rsp_valid_o after that edge. If no new request is taken, rsp_valid_o falls after an edge at which rsp_ready_i was high.
- R3: While rsp_valid_o is high and rsp_ready_i is low, all response fields stay unchanged at the next edge.
- R4: A direct transfer (req_gated_i=0) to a nonconforming target (tgt_conf_i=0) is allowed only when cpl_i equals tgt_dpl_i and rpl_i is at most cpl_i.
- R5: A direct transfer to a conforming target (tgt_conf_i=1) is allowed only when cpl_i is at least tgt_dpl_i. The value of rpl_i has no effect on the outcome.
- R6: A gated transfer (req_gated_i=1) is denied whenever the effective level exceeds gate_dpl_i.
- R7: For a gated transfer that passes the gate check, a jump (req_call_i=0) to a nonconforming target needs cpl_i equal to tgt_dpl_i. A jump to a conforming target, or any call (req_call_i=1), needs cpl_i at least tgt_dpl_i.
- R8: For a gated call to a nonconforming target with tgt_dpl_i below cpl_i, the outcome is rsp_cpl_o = tgt_dpl_i and rsp_stack_sw_o = 1. For every other request, including denied ones, rsp_cpl_o = cpl_i and rsp_stack_sw_o = 0.
- R9: rsp_fault_o is 0 when the transfer is allowed. Otherwise it is 1 for a gate check failure, 2 for a target privilege failure and 3 for a selector level failure, with priority 1 over 2 over 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_call_i | input | 1 | 1 = call, 0 = jump |
| req_gated_i | input | 1 | 1 = entry through a call gate |
| cpl_i | input | 2 | Current privilege level |
| rpl_i | input | 2 | Selector requested privilege level |
| gate_dpl_i | input | 2 | Gate privilege level |
| tgt_dpl_i | input | 2 | Target code segment privilege level |
| tgt_conf_i | input | 1 | Target is conforming |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Consumer takes the response |
| rsp_allow_o | output | 1 | Transfer granted |
| rsp_cpl_o | output | 2 | Privilege level after the transfer |
| rsp_stack_sw_o | output | 1 | Stack switch required |
| rsp_fault_o | output | 2 | Denial reason |

## Verification
The assertions check the following on every cycle: a stalled response stays fixed, an accepted request is answered on the next cycle, the fault code agrees with the grant, and a stack switch never comes with a denial. Whether each rule produces the right verdict, level and fault code across the privilege combinations can only be shown by the bench. The bench sweeps every input combination while applying irregular back-pressure and compares the outputs with a behavioural queue model.

// File: rtl/fxp_pkg.sv
package fxp_pkg;
  parameter int unsigned PL_W = 2;
  typedef logic [PL_W-1:0] pl_t;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_GATE   = 2'd1,
    FLT_TARGET = 2'd2,
    FLT_RPL    = 2'd3
  } fault_e;
  typedef struct packed {
    logic   allow;
    pl_t    new_cpl;
    logic   stack_sw;
    fault_e fault;
  } verdict_t;
  localparam int unsigned VERDICT_W = $bits(verdict_t);
endpackage

// File: rtl/fxp_gate_chk.sv
module fxp_gate_chk
  import fxp_pkg::*;
(
  input  logic gated_i,
  input  pl_t  cpl_i,
  input  pl_t  rpl_i,
  input  pl_t  gate_dpl_i,
  output logic gate_ok_o
);
  pl_t epl;
  always_comb begin
    epl       = (rpl_i > cpl_i) ? rpl_i : cpl_i;
    gate_ok_o = !gated_i || (epl <= gate_dpl_i);
  end
endmodule

// File: rtl/fxp_target_chk.sv
module fxp_target_chk
  import fxp_pkg::*;
(
  input  logic call_i,
  input  logic gated_i,
  input  logic conf_i,
  input  pl_t  cpl_i,
  input  pl_t  rpl_i,
  input  pl_t  tgt_dpl_i,
  output logic tgt_ok_o,
  output logic rpl_ok_o,
  output logic raise_o
);
  logic need_equal;
  always_comb begin
    // exact match: direct nonconforming, or gated jump nonconforming
    need_equal = !conf_i && (!gated_i || !call_i);
    tgt_ok_o   = need_equal ? (cpl_i == tgt_dpl_i) : (cpl_i >= tgt_dpl_i);
    // selector level only matters for direct nonconforming entry
    rpl_ok_o   = gated_i || conf_i || (rpl_i <= cpl_i);
    raise_o    = gated_i && call_i && !conf_i && (tgt_dpl_i < cpl_i);
  end
endmodule

// File: rtl/fxp_resp_reg.sv
module fxp_resp_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_data_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o
);
  logic          vld_q;
  logic [DW-1:0] data_q;

  assign in_ready_o  = !vld_q || out_ready_i;
  assign out_valid_o = vld_q;
  assign out_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
      if (in_valid_i) data_q <= in_data_i;
    end
  end

  // R3
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  // R2
  accept_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  // R2
  drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !in_valid_i) |=> !out_valid_o);
endmodule

// File: rtl/far_xfer_priv_chk.sv
module far_xfer_priv_chk
  import fxp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  output logic       req_ready_o,
  input  logic       req_call_i,
  input  logic       req_gated_i,
  input  logic [1:0] cpl_i,
  input  logic [1:0] rpl_i,
  input  logic [1:0] gate_dpl_i,
  input  logic [1:0] tgt_dpl_i,
  input  logic       tgt_conf_i,
  output logic       rsp_valid_o,
  input  logic       rsp_ready_i,
  output logic       rsp_allow_o,
  output logic [1:0] rsp_cpl_o,
  output logic       rsp_stack_sw_o,
  output logic [1:0] rsp_fault_o
);
  logic     gate_ok, tgt_ok, rpl_ok, raise;
  verdict_t vd, rsp;
  logic [VERDICT_W-1:0] rsp_bits;

  fxp_gate_chk u_gate (
    .gated_i    (req_gated_i),
    .cpl_i      (cpl_i),
    .rpl_i      (rpl_i),
    .gate_dpl_i (gate_dpl_i),
    .gate_ok_o  (gate_ok)
  );

  fxp_target_chk u_tgt (
    .call_i    (req_call_i),
    .gated_i   (req_gated_i),
    .conf_i    (tgt_conf_i),
    .cpl_i     (cpl_i),
    .rpl_i     (rpl_i),
    .tgt_dpl_i (tgt_dpl_i),
    .tgt_ok_o  (tgt_ok),
    .rpl_ok_o  (rpl_ok),
    .raise_o   (raise)
  );

  always_comb begin
    vd.allow    = 1'b0;
    vd.new_cpl  = cpl_i;
    vd.stack_sw = 1'b0;
    vd.fault    = FLT_NONE;
    if (!gate_ok)      vd.fault = FLT_GATE;
    else if (!tgt_ok)  vd.fault = FLT_TARGET;
    else if (!rpl_ok)  vd.fault = FLT_RPL;
    else begin
      vd.allow    = 1'b1;
      vd.stack_sw = raise;
      if (raise) vd.new_cpl = tgt_dpl_i;
    end
  end

  fxp_resp_reg #(.DW(VERDICT_W)) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (req_valid_i),
    .in_ready_o  (req_ready_o),
    .in_data_i   (vd),
    .out_valid_o (rsp_valid_o),
    .out_ready_i (rsp_ready_i),
    .out_data_o  (rsp_bits)
  );

  assign rsp            = verdict_t'(rsp_bits);
  assign rsp_allow_o    = rsp.allow;
  assign rsp_cpl_o      = rsp.new_cpl;
  assign rsp_stack_sw_o = rsp.stack_sw;
  assign rsp_fault_o    = rsp.fault;

  // R9
  allow_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_allow_o) |-> (rsp_fault_o == 2'd0));

  // R9
  deny_has_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_allow_o) |-> (rsp_fault_o != 2'd0));

  // R8
  switch_needs_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_stack_sw_o) |-> rsp_allow_o);

  // R8
  switch_lowers_cpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && vd.stack_sw) |-> (tgt_dpl_i < cpl_i));
endmodule

// File: tb/far_xfer_priv_chk_test.sv
module far_xfer_priv_chk_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_call = 1'b0, req_gated = 1'b0, tgt_conf = 1'b0;
  logic [1:0] cpl = '0, rpl = '0, gate_dpl = '0, tgt_dpl = '0;
  logic       rsp_ready = 1'b0;
  logic       req_ready, rsp_valid, rsp_allow, rsp_stack_sw;
  logic [1:0] rsp_cpl, rsp_fault;

  int checks = 0, fails = 0, cyc = 0;
  logic [5:0] q[$];
  logic       last_acc = 1'b0;
  logic       prev_stall = 1'b0;
  logic [5:0] prev_rsp = '0;
  string      tag_q[$];

  always #10 clk = ~clk;

  far_xfer_priv_chk uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_call_i(req_call), .req_gated_i(req_gated), .cpl_i(cpl), .rpl_i(rpl),
    .gate_dpl_i(gate_dpl), .tgt_dpl_i(tgt_dpl), .tgt_conf_i(tgt_conf),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_allow_o(rsp_allow),
    .rsp_cpl_o(rsp_cpl), .rsp_stack_sw_o(rsp_stack_sw), .rsp_fault_o(rsp_fault)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural rules: {allow, cpl[1:0], sw, fault[1:0]}
  function automatic logic [5:0] expect_of(int call, int gated, int c, int r, int g, int d, int conf);
    int epl = (r > c) ? r : c;
    int ok_t;
    if (gated != 0) begin
      if (epl > g) return {1'b0, 2'(c), 1'b0, 2'd1};
      ok_t = (call == 0 && conf == 0) ? (c == d) : (c >= d);
      if (ok_t == 0) return {1'b0, 2'(c), 1'b0, 2'd2};
      if (call != 0 && conf == 0 && d < c) return {1'b1, 2'(d), 1'b1, 2'd0};
      return {1'b1, 2'(c), 1'b0, 2'd0};
    end
    if (conf != 0) begin
      if (c < d) return {1'b0, 2'(c), 1'b0, 2'd2};
      return {1'b1, 2'(c), 1'b0, 2'd0};
    end
    if (c != d) return {1'b0, 2'(c), 1'b0, 2'd2};
    if (r > c)  return {1'b0, 2'(c), 1'b0, 2'd3};
    return {1'b1, 2'(c), 1'b0, 2'd0};
  endfunction

  function automatic string rule_tag(int gated, int c, int r, int g, int conf);
    int epl = (r > c) ? r : c;
    if (gated != 0) return (epl > g) ? "R6" : "R7";
    return (conf != 0) ? "R5" : "R4";
  endfunction

  // back-pressure pattern
  always @(negedge clk) begin
    cyc++;
    rsp_ready <= ((cyc % 5) != 0) && ((cyc % 7) != 3);
  end

  // reference model update at the edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); tag_q.delete(); last_acc <= 1'b0;
    end else begin
      automatic logic acc = req_valid && (q.size() == 0 || rsp_ready);
      prev_stall <= (q.size() != 0) && !rsp_ready;
      if (q.size() != 0) prev_rsp <= q[0];
      if (q.size() != 0 && rsp_ready) begin void'(q.pop_front()); void'(tag_q.pop_front()); end
      if (acc) begin
        q.push_back(expect_of(req_call, req_gated, cpl, rpl, gate_dpl, tgt_dpl, tgt_conf));
        tag_q.push_back(rule_tag(req_gated, cpl, rpl, gate_dpl, tgt_conf));
      end
      last_acc <= acc;
    end
  end

  // compare every cycle, mid-period
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      check("R2 rsp_valid", rsp_valid, q.size() != 0);
      check("R2 req_ready", req_ready, (q.size() == 0) || rsp_ready);
      if (rsp_valid && q.size() != 0) begin
        if (prev_stall)
          check("R3 held response", {rsp_allow, rsp_cpl, rsp_stack_sw, rsp_fault}, prev_rsp);
        check({tag_q[0], " allow"}, rsp_allow, q[0][5]);
        check("R8 new cpl", rsp_cpl, q[0][4:3]);
        check("R8 stack switch", rsp_stack_sw, q[0][2]);
        check("R9 fault", rsp_fault, q[0][1:0]);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 rsp_valid after reset", rsp_valid, 0);
    check("R1 req_ready after reset", req_ready, 1);
    for (int i = 0; i < 2048; i++) begin
      req_valid = 1'b1;
      {req_call, req_gated, tgt_conf} = 3'(i >> 8);
      {cpl, rpl, gate_dpl, tgt_dpl} = 8'(i);
      forever begin
        @(negedge clk);
        if (last_acc) break;
      end
      if ((i % 16) == 15) begin
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
      end
    end
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    #6;
    check("R2 drained", rsp_valid, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule